// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and calendar date in packed BCD, from seconds up to a two-digit century, in 24-hour form. A set of internal counters moves forward by one second on each pulse of a one-second tick input. Month lengths and leap years are handled automatically: a year whose value is a multiple of four counts as a leap year.

Software sees a second, host-visible copy of the time through a byte-wide register window of sixteen addresses. Two control bits shape how that copy behaves. The read bit freezes the copy so that all fields can be read as one consistent snapshot. The write bit halts the copy so that a new time can be loaded into it. Clearing the write bit moves the loaded time into the internal counters. The internal counters keep running in every case.

After both control bits return to zero, the copy does not follow the internal counters at once. First a qualification count of prescaler enable pulses must complete, and the copy then follows on the next second tick. An oscillator stop bit in the seconds byte freezes all counting.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, the time is century 00, year 00, month 01, date 01, weekday 01, 00:00:00. The oscillator stop bit is 1, the write and read bits are 0, and the seconds byte reads 0x80.
- R2: The window decodes bus_addr[3]=1 with these offsets: 0x8 control, 0x9 seconds, 0xA minutes, 0xB hours, 0xC weekday, 0xD date, 0xE month, 0xF year. The control byte holds the write bit in bit 7, the read bit in bit 6 and the BCD century in bits 5:0. Offsets 0x0-0x7 read 0x00 and ignore writes.
- R3: Seconds bit 7 is the oscillator stop bit. While it is 1, ticks do not advance the internal counters. Writing 0 to it makes every tick advance the time by one second.
- R4: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00, each carrying into the next field. The weekday counts 1 to 7 and returns to 1 at midnight.
- R5: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 31 for the other months; 29 for month 02 when the year is a multiple of four, 28 otherwise. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century, and century 39 wraps to 00.
- R6: While the read bit is 1, the visible copy holds the time it had when the bit was set. The internal counters keep advancing.
- R7: When the read and write bits have both returned to 0, the visible copy stays unchanged until QUAL_TICKS qual_tick pulses have been counted with both bits at 0. On the first second tick after that, the copy shows the internal time again.
- R8: While the write bit is 1, host writes load the visible copy and ticks do not change it. A control write that clears the write bit copies the visible time, with the century from that same write, into the internal counters.
- R9: With the write bit at 0, a write to a time field changes only the visible copy. The next tracked tick replaces it with the internal time.
- R10: While tracking (both bits 0 and qualified), each second tick updates the visible copy to the new internal time in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| qual_tick | input | 1 | Prescaler clock-enable pulse used for release qualification |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from the visible copy (0 when not selected) |

## Verification
Directed loads place the clock one or two seconds before each rollover boundary: minute, hour, midnight with the weekday wrapping from 7, a 30-day month end, and February in both a leap and a non-leap year. Further loads cover the year 99 carry and the century 39 wrap; these cases tell the carry chains apart. Freeze and load sequences interleave ticks and qualification pulses. They show whether the visible copy moves early, moves at all, or takes a stale value, relative to the internal counters modelled in the bench. Random valid times, often sitting on the last second of a day or month, then run for random numbers of ticks. This checks the carry logic against the bench calendar model away from the hand-picked cases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    // low three offset bits inside the upper half of the window
    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_SEC   = 3'd1;
    localparam logic [2:0] OFS_MIN   = 3'd2;
    localparam logic [2:0] OFS_HOUR  = 3'd3;
    localparam logic [2:0] OFS_WDAY  = 3'd4;
    localparam logic [2:0] OFS_DATE  = 3'd5;
    localparam logic [2:0] OFS_MONTH = 3'd6;
    localparam logic [2:0] OFS_YEAR  = 3'd7;

    localparam rtc_time_t RTC_RESET_TIME = '{
        cent: 8'h00, year: 8'h00, month: 8'h01, date: 8'h01,
        wday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'h0};
        else
            return v + 8'd1;
    endfunction

    // last day of a month in BCD; leap test uses (10t+o) mod 4 == (2t+o) mod 4
    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        case (m)
            8'h02:                      return (s[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

    always_comb begin
        nxt    = cur;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        c_cent = 1'b0;

        c_min   = (cur.sec == 8'h59);
        nxt.sec = c_min ? 8'h00 : bcd_inc(cur.sec);

        if (c_min) begin
            c_hour  = (cur.min == 8'h59);
            nxt.min = c_hour ? 8'h00 : bcd_inc(cur.min);
        end
        if (c_hour) begin
            c_day    = (cur.hour == 8'h23);
            nxt.hour = c_day ? 8'h00 : bcd_inc(cur.hour);
        end
        if (c_day) begin
            nxt.wday = (cur.wday == 8'h07) ? 8'h01 : bcd_inc(cur.wday);
            c_mon    = (cur.date == month_last_day(cur.month, cur.year));
            nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
        end
        if (c_mon) begin
            c_year    = (cur.month == 8'h12);
            nxt.month = c_year ? 8'h01 : bcd_inc(cur.month);
        end
        if (c_year) begin
            c_cent   = (cur.year == 8'h99);
            nxt.year = c_cent ? 8'h00 : bcd_inc(cur.year);
        end
        if (c_cent) begin
            nxt.cent = (cur.cent == 8'h39) ? 8'h00 : bcd_inc(cur.cent);
        end
    end
endmodule

// File: rtl/rtc_release_qual.sv
module rtc_release_qual #(
    parameter int QUAL_TICKS = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic qual_tick,
    output logic qualified
);
    localparam int CNT_W = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(QUAL_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_DONE;
        else if (hold)
            cnt_q <= '0;
        else if (qual_tick && (cnt_q != CNT_DONE))
            cnt_q <= cnt_q + 1'b1;
    end

    assign qualified = (cnt_q == CNT_DONE);
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
(
    input  logic       sel,
    input  logic [3:0] addr,
    input  rtc_time_t  vis,
    input  logic       osc_stop,
    input  logic       wr_bit,
    input  logic       rd_bit,
    output logic [7:0] rdata
);
    always_comb begin
        rdata = 8'h00;
        if (sel && addr[3]) begin
            case (addr[2:0])
                OFS_CTRL:  rdata = {wr_bit, rd_bit, vis.cent[5:0]};
                OFS_SEC:   rdata = {osc_stop, vis.sec[6:0]};
                OFS_MIN:   rdata = vis.min;
                OFS_HOUR:  rdata = vis.hour;
                OFS_WDAY:  rdata = vis.wday;
                OFS_DATE:  rdata = vis.date;
                OFS_MONTH: rdata = vis.month;
                default:   rdata = vis.year;
            endcase
        end
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import rtc_pkg::*;
#(
    parameter int QUAL_TICKS = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       qual_tick,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    rtc_time_t core_q, vis_q;
    rtc_time_t core_next, vis_wr;
    logic      osc_stop_q, wr_q, rd_q;
    logic      qualified, tracking;
    logic      host_wr, ctrl_wr, commit, running_tick;

    rtc_advance u_adv (
        .cur (core_q),
        .nxt (core_next)
    );

    rtc_release_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .hold      (wr_q | rd_q),
        .qual_tick (qual_tick),
        .qualified (qualified)
    );

    rtc_read_mux u_rmux (
        .sel      (bus_sel),
        .addr     (bus_addr),
        .vis      (vis_q),
        .osc_stop (osc_stop_q),
        .wr_bit   (wr_q),
        .rd_bit   (rd_q),
        .rdata    (bus_rdata)
    );

    assign host_wr      = bus_sel && bus_wr && bus_addr[3];
    assign ctrl_wr      = host_wr && (bus_addr[2:0] == OFS_CTRL);
    assign commit       = ctrl_wr && wr_q && !bus_wdata[7];
    assign tracking     = !wr_q && !rd_q && qualified;
    assign running_tick = sec_tick && !osc_stop_q;

    // visible copy with the current host write applied
    always_comb begin
        vis_wr = vis_q;
        if (host_wr) begin
            case (bus_addr[2:0])
                OFS_CTRL:  vis_wr.cent  = {2'b00, bus_wdata[5:0]};
                OFS_SEC:   vis_wr.sec   = {1'b0, bus_wdata[6:0]};
                OFS_MIN:   vis_wr.min   = bus_wdata;
                OFS_HOUR:  vis_wr.hour  = bus_wdata;
                OFS_WDAY:  vis_wr.wday  = bus_wdata;
                OFS_DATE:  vis_wr.date  = bus_wdata;
                OFS_MONTH: vis_wr.month = bus_wdata;
                default:   vis_wr.year  = bus_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q     <= RTC_RESET_TIME;
            vis_q      <= RTC_RESET_TIME;
            osc_stop_q <= 1'b1;
            wr_q       <= 1'b0;
            rd_q       <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                wr_q <= bus_wdata[7];
                rd_q <= bus_wdata[6];
            end
            if (host_wr && (bus_addr[2:0] == OFS_SEC))
                osc_stop_q <= bus_wdata[7];

            if (commit)
                core_q <= vis_wr;
            else if (running_tick)
                core_q <= core_next;

            if (host_wr)
                vis_q <= vis_wr;
            else if (tracking && sec_tick)
                vis_q <= osc_stop_q ? core_q : core_next;
        end
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input rtc_time_t  core_q,
    input rtc_time_t  vis_q,
    input logic       osc_stop_q,
    input logic       wr_q,
    input logic       rd_q,
    input logic       qualified
);
    logic any_wr, commit_req;
    assign any_wr     = bus_sel && bus_wr && bus_addr[3];
    assign commit_req = any_wr && (bus_addr[2:0] == 3'd0) && wr_q && !bus_wdata[7];

    // R3: stopped oscillator keeps the internal time still
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (osc_stop_q && !commit_req) |=> $stable(core_q));

    // R3: a running tick always moves the internal time
    a_r3_tick_moves: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !osc_stop_q && !commit_req) |=> (core_q != $past(core_q)));

    // R6/R8: with a control bit set, the copy changes only by host writes
    a_r6_frozen_copy: assert property (@(posedge clk) disable iff (rst)
        ((rd_q || wr_q) && !any_wr) |=> $stable(vis_q));

    // R7: no copy before release qualification completes
    a_r7_wait_qual: assert property (@(posedge clk) disable iff (rst)
        (!qualified && !any_wr) |=> $stable(vis_q));

    // R8: clearing the write bit leaves internal and visible time equal
    a_r8_commit_match: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_q) |-> (core_q == vis_q));

    // R10: tracked tick makes the copy equal the internal time
    a_r10_tick_copy: assert property (@(posedge clk) disable iff (rst)
        (!rd_q && !wr_q && qualified && sec_tick && !any_wr) |=> (vis_q == core_q));
endmodule

bind bcd_calendar_clock rtc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .core_q     (core_q),
    .vis_q      (vis_q),
    .osc_stop_q (osc_stop_q),
    .wr_q       (wr_q),
    .rd_q       (rd_q),
    .qualified  (qualified)
);

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
    localparam int QUAL = 17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       qual_tick = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the internal time, binary fields
    int m_c, m_y, m_mo, m_d, m_wd, m_h, m_mi, m_s;

    always #4 clk = ~clk;

    bcd_calendar_clock #(.QUAL_TICKS(QUAL)) u_dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .qual_tick(qual_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int month_days(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_adv();
        m_s++;
        if (m_s == 60) begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_h++; end
        if (m_h == 24) begin
            m_h = 0;
            m_wd = (m_wd == 7) ? 1 : m_wd + 1;
            m_d++;
            if (m_d > month_days(m_mo, m_y)) begin m_d = 1; m_mo++; end
            if (m_mo == 13) begin m_mo = 1; m_y++; end
            if (m_y == 100) begin m_y = 0; m_c = (m_c == 39) ? 0 : m_c + 1; end
        end
    endtask

    task automatic m_set(input int c, y, mo, d, wd, h, mi, s);
        m_c = c; m_y = y; m_mo = mo; m_d = d; m_wd = wd; m_h = h; m_mi = mi; m_s = s;
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic qticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); qual_tick = 1'b1;
            @(negedge clk); qual_tick = 1'b0;
        end
    endtask

    task automatic expect_vis(input string req, input int c, y, mo, d, wd, h, mi, s,
                              input logic stop, input logic [1:0] ctl);
        logic [7:0] v;
        bus_read(4'h8, v); chk(req, "control", v, {ctl, bcd(c)[5:0]});
        bus_read(4'h9, v); chk(req, "seconds", v, {stop, bcd(s)[6:0]});
        bus_read(4'hA, v); chk(req, "minutes", v, bcd(mi));
        bus_read(4'hB, v); chk(req, "hours",   v, bcd(h));
        bus_read(4'hC, v); chk(req, "weekday", v, bcd(wd));
        bus_read(4'hD, v); chk(req, "date",    v, bcd(d));
        bus_read(4'hE, v); chk(req, "month",   v, bcd(mo));
        bus_read(4'hF, v); chk(req, "year",    v, bcd(y));
    endtask

    task automatic expect_model(input string req);
        expect_vis(req, m_c, m_y, m_mo, m_d, m_wd, m_h, m_mi, m_s, 1'b0, 2'b00);
    endtask

    task automatic write_fields(input int c, y, mo, d, wd, h, mi, s);
        bus_write(4'hF, bcd(y));
        bus_write(4'hE, bcd(mo));
        bus_write(4'hD, bcd(d));
        bus_write(4'hC, bcd(wd));
        bus_write(4'hB, bcd(h));
        bus_write(4'hA, bcd(mi));
        bus_write(4'h9, bcd(s));
        bus_write(4'h8, 8'h80 | bcd(c));
    endtask

    task automatic load(input int c, y, mo, d, wd, h, mi, s);
        bus_write(4'h8, 8'h80 | bcd(c));
        write_fields(c, y, mo, d, wd, h, mi, s);
        bus_write(4'h8, bcd(c));
        m_set(c, y, mo, d, wd, h, mi, s);
        qticks(QUAL);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240229));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_vis("R1", 0, 0, 1, 1, 1, 0, 0, 0, 1'b1, 2'b00);

        // R3: stopped oscillator ignores ticks
        repeat (3) tick();
        bus_read(4'h9, v); chk("R3", "stopped seconds", v, 8'h80);

        // R3: start oscillator, ticks advance (qualified from reset, R10)
        bus_write(4'h9, 8'h00);
        m_set(0, 0, 1, 1, 1, 0, 0, 0);
        tick(); m_adv();
        expect_model("R3");

        // R2: lower half reads zero and ignores writes
        bus_write(4'h3, 8'h55);
        bus_read(4'h3, v); chk("R2", "low offset", v, 8'h00);
        bus_read(4'h9, v); chk("R2", "seconds after low write", v, 8'h01);

        // R8: write mode loads the copy and halts it across ticks
        bus_write(4'h8, 8'hA0);
        write_fields(20, 24, 2, 28, 3, 23, 59, 58);
        tick(); tick();
        expect_vis("R8", 20, 24, 2, 28, 3, 23, 59, 58, 1'b0, 2'b10);
        bus_write(4'h8, 8'h20);
        m_set(20, 24, 2, 28, 3, 23, 59, 58);

        // R7: not yet qualified, copy stays
        qticks(QUAL - 1);
        tick(); m_adv();
        expect_vis("R7", 20, 24, 2, 28, 3, 23, 59, 58, 1'b0, 2'b00);
        qticks(1);
        tick(); m_adv();
        // R5 leap day, R4 weekday, R10 copy
        expect_model("R7");
        bus_read(4'hD, v); chk("R5", "leap date", v, 8'h29);

        // R5: non-leap February
        load(20, 23, 2, 28, 2, 23, 59, 59);
        tick(); m_adv();
        expect_model("R5");
        bus_read(4'hE, v); chk("R5", "march", v, 8'h03);

        // R4/R5: weekday 7 wraps, year 99 carries to century
        load(20, 99, 12, 31, 7, 23, 59, 59);
        tick(); m_adv();
        expect_model("R4");
        bus_read(4'hC, v); chk("R4", "weekday wrap", v, 8'h01);

        // R5: century 39 wraps to 00
        load(39, 99, 12, 31, 5, 23, 59, 59);
        tick(); m_adv();
        expect_model("R5");

        // R5: 30-day month and 31-day month
        load(20, 24, 4, 30, 1, 23, 59, 59);
        tick(); m_adv();
        expect_model("R5");
        load(20, 24, 1, 31, 1, 23, 59, 59);
        tick(); m_adv();
        expect_model("R5");

        // R4: minute and hour carries
        load(20, 25, 6, 15, 2, 10, 59, 58);
        tick(); m_adv();
        tick(); m_adv();
        expect_model("R4");

        // R6: read bit freezes copy, internal keeps counting
        bus_write(4'h8, 8'h60);
        repeat (5) begin tick(); m_adv(); end
        expect_vis("R6", 20, 25, 6, 15, 2, 11, 0, 0, 1'b0, 2'b01);
        bus_write(4'h8, 8'h20);
        qticks(QUAL);
        tick(); m_adv();
        expect_model("R6");

        // R9: write outside write mode touches only the copy
        bus_write(4'hA, 8'h45);
        bus_read(4'hA, v); chk("R9", "visible minutes", v, 8'h45);
        tick(); m_adv();
        expect_model("R9");

        // random valid times near boundaries, random run lengths (R4, R5, R10)
        for (int k = 0; k < 20; k++) begin
            int c, y, mo, d, wd, h, mi, s, n;
            c  = int'($urandom_range(39, 0));
            y  = int'($urandom_range(99, 0));
            mo = int'($urandom_range(12, 1));
            d  = ($urandom_range(1, 0) != 0) ? month_days(mo, y) : int'($urandom_range(28, 1));
            wd = int'($urandom_range(7, 1));
            h  = ($urandom_range(1, 0) != 0) ? 23 : int'($urandom_range(23, 0));
            mi = ($urandom_range(1, 0) != 0) ? 59 : int'($urandom_range(59, 0));
            s  = int'($urandom_range(59, 40));
            n  = int'($urandom_range(40, 1));
            load(c, y, mo, d, wd, h, mi, s);
            for (int t = 0; t < n; t++) begin tick(); m_adv(); end
            expect_model("R10");
        end

        finish_run();
    end
endmodule